// File: doc/BRIEF.md
# I2C Bus Clock and Data Timing Generator

This block paces the SCL line of an I2C master and tells the bit engine when to move SDA. Every interval is counted in system clock cycles from a small set of configuration registers. Two pairs of high/low counts are kept, one for standard speed and one for fast speed. A two-bit speed field picks the pair in use. Fixed offsets are added to the stored counts, and small programmed values are raised to a floor.

While `en_i` and `run_i` are both high, the generator alternates low and high phases. It marks the first cycle of each phase with a one-cycle strobe. Within every low phase it emits two more strobes: one when SDA may change after SCL has fallen, and one when SDA must already hold valid data ahead of the next rise. The high phase counts only the cycles in which the sampled SCL line reads high, so a slave that holds the clock low lengthens it. Configuration writes are accepted only while the block is disabled.

Top module: `i2c_scl_timing`

## Requirements
- R1: A low phase lasts exactly max(low count, 8) + 1 cycles. `scl_o` is 0 for that whole phase, and `scl_fall_o` is high in its first cycle only.
- R2: A high phase lasts max(high count, 6) + 8 cycles in which `scl_i` is sampled high. `scl_rise_o` is high in its first cycle, which is the cycle that follows the last low cycle.
- R3: Bits 2:1 of the control register (select code 0) hold the speed. The value 2 selects the fast pair (high count select 3, low count select 4). Any other value selects the standard pair (high count select 1, low count select 2). Control bit 0 has no effect.
- R4: A stored low count below 8 acts as 8, and a stored high count below 6 acts as 6.
- R5: The hold register (select 5) holds a value h in bits 7:0 and an enable in bit 8. With the enable set, `sda_change_o` pulses h+1 cycles after the `scl_fall_o` cycle, but never later than the last low cycle. With the enable clear, it pulses in the `scl_fall_o` cycle.
- R6: The setup register (select 6) holds an 8-bit value s. `sda_setup_o` pulses s−1 cycles before the `scl_rise_o` cycle. For s of 0 or 1 it pulses together with `scl_rise_o`. When s−1 exceeds the low phase length, it pulses in the `scl_fall_o` cycle.
- R7: Each cycle of the high phase in which `scl_i` is sampled low extends that phase by one cycle.
- R8: A write (`cfg_we_i` high) changes a register only while `en_i` is low. While `en_i` is high, writes have no effect on any later timing.
- R9: With `run_i` low, `scl_o` stays 1 and no phase starts. A running clock completes its current high phase and then stops high. Dropping `en_i` forces `scl_o` to 1 in the next cycle.
- R10: During reset `scl_o` is 1 and all four strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable; locks the configuration |
| run_i | input | 1 | Bit engine requests SCL toggling |
| scl_i | input | 1 | Sampled level of the SCL line |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select: 0 control, 1 std high, 2 std low, 3 fast high, 4 fast low, 5 hold, 6 setup |
| cfg_wdata_i | input | CNT_W | Write data |
| scl_o | output | 1 | SCL level to drive (1 = release) |
| scl_fall_o | output | 1 | First cycle of a low phase |
| scl_rise_o | output | 1 | First cycle of a high phase |
| sda_change_o | output | 1 | SDA may change now |
| sda_setup_o | output | 1 | SDA must be valid from now until the rise |

## Verification
The assertions assume two things about the inputs. First, the configuration is written only while the block is disabled, or the write is discarded. Second, `scl_i` never shows high while the block drives SCL low. Together these keep the phase lengths fixed during a run and keep every strobe at one pulse per period. The bench feeds `scl_i` back from `scl_o`, and it only ever adds a low hold right after a rise to model stretching. It programs registers with `en_i` low, apart from one deliberate write under enable that checks the lock.

// File: rtl/i2c_tim_pkg.sv
package i2c_tim_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_STD_HI  = 3'd1,
    SEL_STD_LO  = 3'd2,
    SEL_FAST_HI = 3'd3,
    SEL_FAST_LO = 3'd4,
    SEL_HOLD    = 3'd5,
    SEL_SETUP   = 3'd6
  } cfg_sel_e;

  localparam logic [1:0] SPEED_FAST = 2'd2;
  localparam int LO_MIN = 8;
  localparam int HI_MIN = 6;
  localparam int LO_ADD = 1;
  localparam int HI_ADD = 8;
  localparam int NUM_CNT = 4;  // std hi, std lo, fast hi, fast lo

endpackage

// File: rtl/i2c_tim_cfg.sv
module i2c_tim_cfg import i2c_tim_pkg::*; #(
  parameter  int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [LEN_W-1:0] lo_len_o,
  output logic [LEN_W-1:0] hi_len_o,
  output logic             hold_en_o,
  output logic [7:0]       hold_val_o,
  output logic [7:0]       setup_val_o
);

  logic             wr_ok;
  logic [1:0]       speed_q;
  logic [8:0]       hold_q;
  logic [7:0]       setup_q;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic             fast;
  logic [CNT_W-1:0] hi_raw, lo_raw, hi_eff, lo_eff;

  assign wr_ok = we_i && !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q <= 2'd1;
      hold_q  <= '0;
      setup_q <= '0;
    end else if (wr_ok) begin
      if (sel_i == SEL_CTRL)  speed_q <= wdata_i[2:1];
      if (sel_i == SEL_HOLD)  hold_q  <= wdata_i[8:0];
      if (sel_i == SEL_SETUP) setup_q <= wdata_i[7:0];
    end
  end

  // count slot g maps to select code g+1
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cnt_q[g] <= '0;
      else if (wr_ok && sel_i == 3'(g + 1))  cnt_q[g] <= wdata_i;
    end
  end

  always_comb begin
    fast   = (speed_q == SPEED_FAST);
    hi_raw = fast ? cnt_q[2] : cnt_q[0];
    lo_raw = fast ? cnt_q[3] : cnt_q[1];
    hi_eff = (hi_raw < CNT_W'(HI_MIN)) ? CNT_W'(HI_MIN) : hi_raw;
    lo_eff = (lo_raw < CNT_W'(LO_MIN)) ? CNT_W'(LO_MIN) : lo_raw;
  end

  assign hi_len_o    = {1'b0, hi_eff} + LEN_W'(HI_ADD);
  assign lo_len_o    = {1'b0, lo_eff} + LEN_W'(LO_ADD);
  assign hold_en_o   = hold_q[8];
  assign hold_val_o  = hold_q[7:0];
  assign setup_val_o = setup_q;

  a_r8_locked_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> $stable(lo_len_o) && $stable(hi_len_o) && $stable(hold_q) && $stable(setup_q));

  a_r4_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_len_o >= LEN_W'(LO_MIN + LO_ADD) && hi_len_o >= LEN_W'(HI_MIN + HI_ADD));

endmodule

// File: rtl/i2c_tim_phase.sv
module i2c_tim_phase import i2c_tim_pkg::*; #(
  parameter  int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             scl_i,
  input  logic [LEN_W-1:0] lo_len_i,
  input  logic [LEN_W-1:0] hi_len_i,
  output logic             scl_o,
  output logic             fall_o,
  output logic             rise_o,
  output logic             in_low_o,
  output logic [LEN_W-1:0] el_o
);

  phase_e           state_q;
  logic [LEN_W-1:0] el_q;
  logic             rise_q;
  logic             lo_last, hi_last;

  assign lo_last = (el_q == lo_len_i - LEN_W'(1));
  assign hi_last = (el_q == hi_len_i - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      el_q    <= '0;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (!en_i) begin
        state_q <= PH_IDLE;
        el_q    <= '0;
      end else begin
        unique case (state_q)
          PH_IDLE: if (run_i) begin
            state_q <= PH_LOW;
            el_q    <= '0;
          end
          PH_LOW: if (lo_last) begin
            state_q <= PH_HIGH;
            el_q    <= '0;
            rise_q  <= 1'b1;
          end else begin
            el_q <= el_q + LEN_W'(1);
          end
          PH_HIGH: if (scl_i) begin  // stretched cycles are not counted
            if (hi_last) begin
              state_q <= run_i ? PH_LOW : PH_IDLE;
              el_q    <= '0;
            end else begin
              el_q <= el_q + LEN_W'(1);
            end
          end
          default: state_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign scl_o    = (state_q != PH_LOW);
  assign in_low_o = (state_q == PH_LOW);
  assign fall_o   = in_low_o && (el_q == '0);
  assign rise_o   = rise_q;
  assign el_o     = el_q;

  a_r1_fall_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(scl_o));

  a_r1_low_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LOW) |-> el_q < lo_len_i);

  a_r2_rise_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> scl_o && !$past(scl_o));

  a_r2_high_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_HIGH) |-> el_q < hi_len_i);

  a_r7_stretch_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_HIGH && en_i && !scl_i) |=> $stable(el_q));

  a_r9_disable_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> scl_o && !fall_o);

endmodule

// File: rtl/i2c_tim_sda.sv
module i2c_tim_sda #(
  parameter  int CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_low_i,
  input  logic             rise_i,
  input  logic [LEN_W-1:0] el_i,
  input  logic [LEN_W-1:0] lo_len_i,
  input  logic             hold_en_i,
  input  logic [7:0]       hold_val_i,
  input  logic [7:0]       setup_val_i,
  output logic             sda_change_o,
  output logic             sda_setup_o
);

  logic [LEN_W-1:0] hold_dly, lo_end, hold_tgt, su_w, su_tgt;

  always_comb begin
    hold_dly = LEN_W'(hold_val_i) + LEN_W'(1);
    lo_end   = lo_len_i - LEN_W'(1);
    if (!hold_en_i)           hold_tgt = '0;
    else if (hold_dly < lo_end) hold_tgt = hold_dly;
    else                      hold_tgt = lo_end;  // clamp to last low cycle

    // target counted from the fall; lo_len means the rise cycle itself
    su_w = LEN_W'(setup_val_i);
    if (su_w <= LEN_W'(1))    su_tgt = lo_len_i;
    else if (su_w > lo_len_i) su_tgt = '0;
    else                      su_tgt = lo_len_i - su_w + LEN_W'(1);
  end

  assign sda_change_o = in_low_i && (el_i == hold_tgt);
  assign sda_setup_o  = (in_low_i && (el_i == su_tgt)) || (rise_i && (su_tgt == lo_len_i));

  a_r5_single_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_change_o |=> !sda_change_o);

  a_r6_single_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_setup_o |=> !sda_setup_o);

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             scl_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  output logic             scl_o,
  output logic             scl_fall_o,
  output logic             scl_rise_o,
  output logic             sda_change_o,
  output logic             sda_setup_o
);

  localparam int LEN_W = CNT_W + 1;

  logic [LEN_W-1:0] lo_len, hi_len, el;
  logic             hold_en, in_low;
  logic [7:0]       hold_val, setup_val;

  i2c_tim_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .wdata_i     (cfg_wdata_i),
    .lo_len_o    (lo_len),
    .hi_len_o    (hi_len),
    .hold_en_o   (hold_en),
    .hold_val_o  (hold_val),
    .setup_val_o (setup_val)
  );

  i2c_tim_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .run_i    (run_i),
    .scl_i    (scl_i),
    .lo_len_i (lo_len),
    .hi_len_i (hi_len),
    .scl_o    (scl_o),
    .fall_o   (scl_fall_o),
    .rise_o   (scl_rise_o),
    .in_low_o (in_low),
    .el_o     (el)
  );

  i2c_tim_sda #(.CNT_W(CNT_W)) u_sda (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_low_i     (in_low),
    .rise_i       (scl_rise_o),
    .el_i         (el),
    .lo_len_i     (lo_len),
    .hold_en_i    (hold_en),
    .hold_val_i   (hold_val),
    .setup_val_i  (setup_val),
    .sda_change_o (sda_change_o),
    .sda_setup_o  (sda_setup_o)
  );

  a_r5_change_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_change_o |-> !scl_o);

  a_r6_setup_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_setup_o |-> (!scl_o || scl_rise_o));

  a_r1_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_fall_o && scl_rise_o));

endmodule

// File: tb/i2c_scl_timing_tb.sv
module i2c_scl_timing_tb;

  localparam int CW = 16;
  localparam int NV = 6;
  // speed, std_lo, std_hi, fast_lo, fast_hi, hold, setup | exp low, high, hold offset, setup lead
  localparam int VEC [NV][11] = '{
    '{1, 20, 10, 40, 40, 'h105,  4, 21, 18,  6,  3},
    '{2, 50, 50, 12,  7, 'h000,  1, 13, 15,  0,  0},
    '{1,  3,  2, 99, 99, 'h103,  0,  9, 14,  4,  0},
    '{2,  5,  5, 30, 20, 'h1FF, 50, 31, 28, 30, 31},
    '{3, 15,  9,  7,  7, 'h100,  2, 16, 17,  1,  1},
    '{0,  8,  6, 60, 60, 'h107,  9,  9, 14,  8,  8}
  };

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, run = 1'b0, we = 1'b0, stretch = 1'b0;
  logic [2:0]    sel = '0;
  logic [CW-1:0] wd  = '0;
  logic scl_o, fall, rise, chg, su;
  logic scl_line;

  assign scl_line = scl_o & ~stretch;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  i2c_scl_timing #(.CNT_W(CW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .run_i        (run),
    .scl_i        (scl_line),
    .cfg_we_i     (we),
    .cfg_sel_i    (sel),
    .cfg_wdata_i  (wd),
    .scl_o        (scl_o),
    .scl_fall_o   (fall),
    .scl_rise_o   (rise),
    .sda_change_o (chg),
    .sda_setup_o  (su)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input int d);
    @(negedge clk); we = 1'b1; sel = 3'(s); wd = CW'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic load(input int i);
    @(negedge clk); en = 1'b0; run = 1'b0;
    wr(0, VEC[i][0] << 1);
    wr(2, VEC[i][1]);
    wr(1, VEC[i][2]);
    wr(4, VEC[i][3]);
    wr(3, VEC[i][4]);
    wr(5, VEC[i][5]);
    wr(6, VEC[i][6]);
    @(negedge clk); en = 1'b1;
  endtask

  // one full period from a fall to the next fall
  task automatic measure(input int sn, output int lo_n, output int hi_n,
                         output int hk, output int sb);
    int t, r_t, su_t;
    hk = -1; su_t = -1; r_t = -1; hi_n = -1;
    @(negedge clk); run = 1'b1;
    t = 0;
    while (!fall && t < 2000) begin @(negedge clk); t++; end
    t = 0;
    while (t < 4000) begin
      if (chg && hk < 0)  hk = t;
      if (su && su_t < 0) su_t = t;
      if (rise && r_t < 0) r_t = t;
      if (fall && t > 0) begin
        hi_n = (r_t >= 0) ? t - r_t : -1;
        break;
      end
      stretch = (r_t >= 0) && (t - r_t < sn);
      @(negedge clk);
      t++;
    end
    stretch = 1'b0;
    run = 1'b0;
    lo_n = r_t;
    sb = (r_t >= 0 && su_t >= 0) ? r_t - su_t : -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lo_n, hi_n, hk, sb, nf, nlow;

    // R10: reset state
    repeat (2) @(negedge clk);
    chk("R10 reset outputs", int'({scl_o, fall, rise, chg, su}), 16);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: enabled but not running stays high
    en = 1'b1;
    nf = 0; nlow = 0;
    repeat (30) begin @(negedge clk); nf += int'(fall); nlow += int'(!scl_o); end
    chk("R9 idle no fall", nf, 0);
    chk("R9 idle scl high", nlow, 0);

    // R1 R2 R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      load(i);
      measure(0, lo_n, hi_n, hk, sb);
      chk($sformatf("R1 R3 R4 low length v%0d", i), lo_n, VEC[i][7]);
      chk($sformatf("R2 R3 R4 high length v%0d", i), hi_n, VEC[i][8]);
      chk($sformatf("R5 hold offset v%0d", i), hk, VEC[i][9]);
      chk($sformatf("R6 setup lead v%0d", i), sb, VEC[i][10]);
    end

    // R7: slave holds SCL low for 5 cycles after the rise
    load(0);
    measure(5, lo_n, hi_n, hk, sb);
    chk("R7 stretched high", hi_n, 23);
    chk("R7 low unaffected", lo_n, 21);

    // R8: writes under enable are dropped
    repeat (60) @(negedge clk);
    wr(2, 100);
    wr(0, 2 << 1);
    measure(0, lo_n, hi_n, hk, sb);
    chk("R8 low kept", lo_n, 21);
    chk("R8 high kept", hi_n, 18);

    // R9: run dropped, clock finishes and parks high
    repeat (100) @(negedge clk);
    nf = 0; nlow = 0;
    repeat (100) begin @(negedge clk); nf += int'(fall); nlow += int'(!scl_o); end
    chk("R9 stopped no fall", nf, 0);
    chk("R9 stopped scl high", nlow, 0);

    // R9: disable during a low phase releases SCL next cycle
    @(negedge clk); run = 1'b1;
    nf = 0;
    while (!fall && nf < 100) begin @(negedge clk); nf++; end
    repeat (2) @(negedge clk);
    chk("R9 low before disable", int'(scl_o), 0);
    en = 1'b0;
    @(negedge clk);
    chk("R9 disable releases scl", int'(scl_o), 1);
    run = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule